// File: doc/BRIEF.md
# ADC Result Register Read Interlock

This block sits between an analog-to-digital converter and the register bus. It keeps the most recent 10-bit conversion result and lets software fetch it as two 8-bit bytes, a low byte and a high byte. A control input picks how the 10 bits sit inside the 16-bit byte pair: packed against bit 0 (right-justified, the reset choice) or packed against bit 15 (left-justified). The formatting is applied on the read path, so flipping the control reshapes the visible bytes in the same cycle, even while a conversion is running.

Reading the two bytes is made coherent by an interlock. A low-byte read locks the visible result. Conversions that finish while the lock is held go to a one-entry holding register, and a later arrival replaces an earlier one. The high-byte read releases the lock, and the held value, or a result arriving in that same cycle, becomes visible on the following edge. When software only needs 8 bits, it sets left-justify and reads the high byte alone. This never locks anything.

`rd_data` always shows the byte chosen by `rd_hi`. Only a cycle with `rd_en` high counts as a bus read for the interlock.

Top module: `adc_result_interlock`

## Requirements
- R1: After synchronous reset, the stored result is zero, both bytes read 0x00 under either justification, and the register is unlocked.
- R2: With `left_adj` = 0, the low byte is result bits 7:0 and the high byte is {6'b0, result bits 9:8}.
- R3: With `left_adj` = 1, the high byte is result bits 9:2 and the low byte is {result bits 1:0, 6'b0}.
- R4: A change of `left_adj` changes `rd_data` in the same cycle, without waiting for a clock edge.
- R5: While unlocked, a `conv_done` pulse makes `conv_data` visible from the next clock edge.
- R6: A read with `rd_en` = 1 and `rd_hi` = 0 locks the register. Until a read with `rd_hi` = 1, no conversion alters the visible result.
- R7: Results that arrive while locked, including in the cycle of the locking low read, are held pending, and the newest one wins. On the high-byte read that releases the lock, the pending value becomes visible at the next edge.
- R8: A conversion that completes in the same cycle as the releasing high-byte read becomes visible at the next edge and replaces any pending value.
- R9: A high-byte read never sets the lock. Later conversions update the visible result normally.
- R10: Bits of the 16-bit pair that do not carry result bits read as zero in both justifications.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a conversion result is ready |
| conv_data | input | 10 | Conversion result, valid with `conv_done` |
| left_adj | input | 1 | 1 = left-justified view, 0 = right-justified |
| rd_en | input | 1 | Bus read strobe for one of the two bytes |
| rd_hi | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| rd_data | output | 8 | Selected byte of the formatted result |

## Verification
The bench goes after conversions that land in the same cycle as the low read or the high read. A design that checked only the registered lock would let the first of these overwrite the byte pair mid-read. A design that ignored the second would lose the newest result.

It sends several conversions during one lock. A design that kept the first pending value instead of the last would show stale data after release.

It also does a high-only read under left-justify and then sends a further conversion. This catches a design that locks on any read, because that conversion would never appear.

Justification is flipped between clock edges and sampled at once. A registered formatter would show the old view there.

// File: rtl/adcri_pkg.sv
package adcri_pkg;
  localparam int unsigned DEF_RES_W  = 10;
  localparam int unsigned DEF_BYTE_W = 8;

  typedef enum logic {
    BYTE_LO = 1'b0,
    BYTE_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/adcri_lock_ctrl.sv
module adcri_lock_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic rd_lo_stb,
  input  logic rd_hi_stb,
  output logic lock_q,
  output logic lock_eff,
  output logic release_evt
);
  // Lock is taken on a low read and dropped on a high read.
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
    end else if (rd_lo_stb) begin
      lock_q <= 1'b1;
    end else if (rd_hi_stb) begin
      lock_q <= 1'b0;
    end
  end

  // A low read in this cycle already protects the pair being read.
  assign lock_eff    = lock_q | rd_lo_stb;
  assign release_evt = lock_q & rd_hi_stb;
endmodule

// File: rtl/adcri_result_store.sv
module adcri_result_store #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             lock_eff,
  input  logic             release_evt,
  output logic [RES_W-1:0] vis_data,
  output logic [RES_W-1:0] pend_data,
  output logic             pend_v,
  output logic             load_evt,
  output logic             park_evt
);
  assign park_evt = conv_done & lock_eff & ~release_evt;
  assign load_evt = (conv_done & ~lock_eff) | (release_evt & (conv_done | pend_v));

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_data  <= '0;
      pend_data <= '0;
      pend_v    <= 1'b0;
    end else if (release_evt) begin
      if (conv_done) begin
        vis_data <= conv_data;
      end else if (pend_v) begin
        vis_data <= pend_data;
      end
      pend_v <= 1'b0;
    end else if (conv_done) begin
      if (lock_eff) begin
        pend_data <= conv_data;
        pend_v    <= 1'b1;
      end else begin
        vis_data <= conv_data;
      end
    end
  end
endmodule

// File: rtl/adcri_justify.sv
module adcri_justify #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [RES_W-1:0]  vis_data,
  input  logic              left_adj,
  input  adcri_pkg::byte_sel_e sel,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int unsigned PAIR_W = 2 * BYTE_W;
  localparam int unsigned PAD_W  = PAIR_W - RES_W;

  function automatic logic [PAIR_W-1:0] fmt_pair(input logic [RES_W-1:0] r,
                                                 input logic left);
    logic [PAIR_W-1:0] p;
    if (left) p = {r, {PAD_W{1'b0}}};
    else      p = {{PAD_W{1'b0}}, r};
    return p;
  endfunction

  logic [PAIR_W-1:0] pair;
  assign pair     = fmt_pair(vis_data, left_adj);
  assign byte_out = (sel == adcri_pkg::BYTE_HI) ? pair[PAIR_W-1:BYTE_W]
                                                : pair[BYTE_W-1:0];
endmodule

// File: rtl/adc_result_interlock.sv
module adc_result_interlock #(
  parameter int unsigned RES_W  = adcri_pkg::DEF_RES_W,
  parameter int unsigned BYTE_W = adcri_pkg::DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              left_adj,
  input  logic              rd_en,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data
);
  logic rd_lo_stb, rd_hi_stb;
  logic lock_q, lock_eff, release_evt;
  logic [RES_W-1:0] vis_data, pend_data;
  logic pend_v, load_evt, park_evt;
  adcri_pkg::byte_sel_e sel;

  assign sel       = rd_hi ? adcri_pkg::BYTE_HI : adcri_pkg::BYTE_LO;
  assign rd_lo_stb = rd_en & ~rd_hi;
  assign rd_hi_stb = rd_en & rd_hi;

  adcri_lock_ctrl u_lock (
    .clk(clk), .rst(rst),
    .rd_lo_stb(rd_lo_stb), .rd_hi_stb(rd_hi_stb),
    .lock_q(lock_q), .lock_eff(lock_eff), .release_evt(release_evt)
  );

  adcri_result_store #(.RES_W(RES_W)) u_store (
    .clk(clk), .rst(rst),
    .conv_done(conv_done), .conv_data(conv_data),
    .lock_eff(lock_eff), .release_evt(release_evt),
    .vis_data(vis_data), .pend_data(pend_data), .pend_v(pend_v),
    .load_evt(load_evt), .park_evt(park_evt)
  );

  adcri_justify #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_just (
    .vis_data(vis_data), .left_adj(left_adj), .sel(sel), .byte_out(rd_data)
  );
endmodule

// File: rtl/adcri_checker.sv
module adcri_checker #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_data,
  input logic              left_adj,
  input logic              rd_en,
  input logic              rd_hi,
  input logic [BYTE_W-1:0] rd_data,
  input logic              lock_q,
  input logic              pend_v,
  input logic [RES_W-1:0]  pend_data,
  input logic [RES_W-1:0]  vis_data
);
  localparam int unsigned PAD_W = 2 * BYTE_W - RES_W;

  AST_LOCKED_VIS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !(rd_en && rd_hi)) |=> $stable(vis_data)); // R6
  AST_LOW_READ_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hi) |=> lock_q); // R6
  AST_HIGH_READ_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_hi) |=> !lock_q); // R9
  AST_UNLOCKED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !lock_q && !rd_en) |=> (vis_data == $past(conv_data))); // R5
  AST_PEND_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> lock_q); // R7
  AST_RELEASE_TRANSFER: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_hi && lock_q && pend_v && !conv_done) |=> (vis_data == $past(pend_data))); // R7
  AST_RELEASE_NEWEST: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_hi && lock_q && conv_done) |=> (vis_data == $past(conv_data))); // R8
  AST_RIGHT_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!left_adj && rd_hi) |-> (rd_data[BYTE_W-1:RES_W-BYTE_W] == '0)); // R10
  AST_LEFT_LO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (left_adj && !rd_hi) |-> (rd_data[PAD_W-1:0] == '0)); // R10
endmodule

bind adc_result_interlock adcri_checker #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
  .left_adj(left_adj), .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data),
  .lock_q(lock_q), .pend_v(pend_v), .pend_data(pend_data), .vis_data(vis_data)
);

// File: tb/test_adc_result_interlock.sv
module test_adc_result_interlock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       left_adj = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] rd_data;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  adc_result_interlock i_adc_result_interlock (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
    .left_adj(left_adj), .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_byte(input logic [9:0] r, input logic left, input logic hi);
    logic [15:0] w;
    w = left ? ({6'b0, r} << 6) : {6'b0, r};
    return hi ? w[15:8] : w[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Look at a byte without a bus read strobe (no lock side effects).
  task automatic peek(input logic hi, input string req, input logic [7:0] exp);
    rd_hi = hi;
    #1;
    check(req, rd_data, exp);
  endtask

  // One clock of stimulus starting at a negedge; rd_data sampled before the edge.
  task automatic cycle(input logic cd, input logic [9:0] d, input logic re, input logic hi,
                       output logic [7:0] got);
    conv_done = cd; conv_data = d; rd_en = re; rd_hi = hi;
    #1; got = rd_data;
    @(negedge clk);
    conv_done = 1'b0; rd_en = 1'b0;
  endtask

  task automatic t_reset;
    left_adj = 1'b0;
    peek(1'b0, "R1", 8'h00); peek(1'b1, "R1", 8'h00);
    left_adj = 1'b1;
    peek(1'b0, "R1", 8'h00); peek(1'b1, "R1", 8'h00);
    left_adj = 1'b0;
  endtask

  task automatic t_justify;
    logic [7:0] g;
    cycle(1'b1, 10'h2A5, 1'b0, 1'b0, g);
    peek(1'b0, "R5", exp_byte(10'h2A5, 1'b0, 1'b0));
    peek(1'b0, "R2", 8'hA5);
    peek(1'b1, "R2", 8'h02);
    peek(1'b1, "R10", {6'b0, rd_data[1:0]});
    left_adj = 1'b1;
    peek(1'b1, "R3", 8'hA9);
    peek(1'b0, "R3", 8'h40);
    // R4: flip mid-cycle and look without an edge in between
    @(posedge clk); #2;
    left_adj = 1'b0; rd_hi = 1'b1; #1;
    check("R4", rd_data, 8'h02);
    left_adj = 1'b1; #1;
    check("R4", rd_data, 8'hA9);
    left_adj = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_lock_pending;
    logic [7:0] g;
    cycle(1'b0, 10'h0, 1'b1, 1'b0, g);          // low read locks
    check("R6", g, 8'hA5);
    cycle(1'b1, 10'h3FF, 1'b0, 1'b0, g);
    cycle(1'b1, 10'h155, 1'b0, 1'b0, g);
    peek(1'b1, "R6", 8'h02);
    peek(1'b0, "R6", 8'hA5);
    cycle(1'b0, 10'h0, 1'b1, 1'b1, g);          // high read releases
    check("R6", g, 8'h02);
    peek(1'b0, "R7", 8'h55);                    // newest pending wins
    peek(1'b1, "R7", 8'h01);
  endtask

  task automatic t_same_cycle;
    logic [7:0] g;
    cycle(1'b1, 10'h0F0, 1'b1, 1'b0, g);        // conversion with locking read
    check("R7", g, 8'h55);
    peek(1'b0, "R7", 8'h55);
    cycle(1'b0, 10'h0, 1'b1, 1'b1, g);
    check("R7", g, 8'h01);
    peek(1'b0, "R7", 8'hF0);
    peek(1'b1, "R7", 8'h00);
    cycle(1'b0, 10'h0, 1'b1, 1'b0, g);          // lock again
    cycle(1'b1, 10'h011, 1'b0, 1'b0, g);        // pending
    cycle(1'b1, 10'h300, 1'b1, 1'b1, g);        // conversion with releasing read
    check("R8", g, 8'h00);
    peek(1'b1, "R8", 8'h03);
    peek(1'b0, "R8", 8'h00);
  endtask

  task automatic t_high_only;
    logic [7:0] g;
    left_adj = 1'b1;
    cycle(1'b1, 10'h3C3, 1'b0, 1'b0, g);
    cycle(1'b0, 10'h0, 1'b1, 1'b1, g);
    check("R9", g, 8'hF0);
    cycle(1'b1, 10'h001, 1'b0, 1'b0, g);
    peek(1'b1, "R9", 8'h00);
    peek(1'b0, "R9", 8'h40);
    peek(1'b0, "R10", exp_byte(10'h001, 1'b1, 1'b0));
    left_adj = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_justify;
    t_lock_pending;
    t_same_cycle;
    t_high_only;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule